// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a single-port synchronous memory with a 36-bit word made of four 9-bit byte lanes. Its depth is set by a parameter. Address, write data, chip selects, burst controls and write controls are all captured on the rising clock edge. An access starts when one of two active-low address strobes is asserted: the host strobe or the controller strobe. After that, a 2-bit burst counter produces the low two address bits of each later word. The counter moves only when the active-low advance input is asserted. In any cycle with no strobe and no advance, the same word is accessed again.

Each access is a write or a read. A global-write input stores all four lanes. Otherwise the per-lane enables store only their own lanes, and only while the gating input is low. If no lane is written, the cycle is a read. Read data is registered and appears one clock after the address is captured. It leaves the block only while the output enable is low, and a drive flag stands in for a tri-state pad. The burst-order select, the output enable and the sleep input act without a clock. Sleep freezes the block and keeps the memory contents.

Top module: `burst_sram`

## Requirements
- R1: During and after reset, and before any access starts, `rdata_drv` is 0 and `rdata` is 0.
- R2: A read started at address A puts the stored word of A on `rdata`, with `rdata_drv` = 1, after the first rising edge that follows the capture. This holds while `oe_n` = 0 and `sleep` = 0.
- R3: In linear order (`order_sel` = 0), the low two address bits step through start+0, +1, +2, +3 modulo 4. Each edge with `adv_n` = 0 and no strobe makes one step. The upper bits stay fixed, and the sequence wraps back to the start word. An edge with `adv_n` = 1 and no strobe accesses the same word again.
- R4: In interleaved order (`order_sel` = 1), the low two address bits are the start bits XOR the count 0, 1, 2, 3.
- R5: `lane_en_n[i]` = 0 writes bits 9i+8 down to 9i (lane 0 is bits 8:0, lane 3 is bits 35:27), but only while `wr_gate_n` = 0. While `wr_gate_n` = 1 and `wr_all_n` = 1, the lane enables are ignored and the cycle is a read.
- R6: `wr_all_n` = 0 writes all four lanes, whatever the values of `wr_gate_n` and `lane_en_n`.
- R7: A strobe selects the device only if `ce_a_n` = 0, `ce_b` = 1 and `ce_c_n` = 0. Any other combination deselects it. A deselected device performs no write and does not drive `rdata`.
- R8: A host strobe is ignored while `ce_a_n` = 1, and the current burst continues. A controller strobe is accepted while `ce_a_n` = 1 and deselects the device. When both strobes are low, the host strobe wins, so the controller strobe acts only when `ce_a_n` = 1.
- R9: `oe_n` = 1 forces `rdata_drv` and `rdata` to 0 at once, without a clock edge. Setting `oe_n` back to 0 restores the registered word.
- R10: While `sleep` = 1, no write takes effect and the burst counter and strobes are ignored. The output is not driven, and this takes effect without a clock edge. After `sleep` returns to 0, the held word and the held count are still in place.
- R11: The cycle after a write access, `rdata_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, captured with a strobe |
| wdata | input | LANES*LANE_W | Write data, captured at each access |
| ce_a_n | input | 1 | Active-low chip select; also qualifies the host strobe |
| ce_b | input | 1 | Active-high chip select |
| ce_c_n | input | 1 | Active-low chip select |
| strb_host_n | input | 1 | Active-low host address strobe |
| strb_ctl_n | input | 1 | Active-low controller address strobe |
| adv_n | input | 1 | Active-low burst advance |
| wr_all_n | input | 1 | Active-low global write of all lanes |
| wr_gate_n | input | 1 | Active-low gate for the per-lane enables |
| lane_en_n | input | LANES | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Asynchronous sleep: blocks accesses, keeps contents |
| rdata | output | LANES*LANE_W | Registered read word, 0 when not driven |
| rdata_drv | output | 1 | High while `rdata` is being driven |

## Verification
The bound checker examines every clock cycle. It checks that sleep blocks every access, and that a deselecting controller strobe never produces an access. It checks that global write forces a full lane mask, and that the lane enables produce no write while the gate is high. It also checks that a write is never followed by output drive, that a read is followed by drive exactly when output enable and sleep allow it, and that a suspended cycle keeps its address. Only the bench's scenarios can show the actual data paths. These cover the word returned for each linear and interleaved burst position, the merge of partly written lanes, the host strobe being ignored while a burst continues, and memory and counter contents surviving a sleep interval.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 9;
    localparam int DEF_ADDR_W = 8;
    localparam int BURST_W    = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // low address bits of burst position cnt from start value strt
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] strt,
        input logic [BURST_W-1:0] cnt,
        input burst_order_e       ord
    );
        if (ord == ORDER_INTERLEAVED)
            return strt ^ cnt;
        else
            return strt + cnt;
    endfunction

endpackage

// File: rtl/bsram_wmask.sv
module bsram_wmask #(
    parameter int LANES = bsram_pkg::DEF_LANES
) (
    input  logic             wr_all_n,
    input  logic             wr_gate_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic [LANES-1:0] wmask
);

    // global write overrides; per-lane enables need the gate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wmask[g] = !wr_all_n || (!wr_gate_n && !lane_en_n[g]);
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              strb_host_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic              sleep,
    output logic              acc_en,
    output logic [ADDR_W-1:0] acc_addr
);

    typedef struct packed {
        logic                active;
        logic [ADDR_W-1:0]   base;
        logic [BURST_W-1:0]  cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  start_host, start_ctl, selected;

    always_comb begin
        st_d       = st_q;
        start_host = !strb_host_n && !ce_a_n;
        start_ctl  = !strb_ctl_n && !start_host;
        selected   = !ce_a_n && ce_b && !ce_c_n;
        if (!sleep) begin
            if (start_host || start_ctl) begin
                st_d.active = selected;
                st_d.base   = addr;
                st_d.cnt    = '0;
            end else if (st_q.active && !adv_n) begin
                st_d.cnt = st_q.cnt + BURST_W'(1);
            end
        end
        acc_en   = !sleep && st_d.active;
        acc_addr = {st_d.base[ADDR_W-1:BURST_W],
                    burst_low(st_d.base[BURST_W-1:0], st_d.cnt,
                              burst_order_e'(order_sel))};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = bsram_pkg::DEF_ADDR_W,
    parameter int LANES  = bsram_pkg::DEF_LANES,
    parameter int LANE_W = bsram_pkg::DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    rd_drv,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              drv;
        logic [WORD_W-1:0] data;
    } rd_t;

    rd_t               rd_d, rd_q;
    logic [WORD_W-1:0] rd_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (acc_en && wmask[g]) begin
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[acc_addr];
    end

    always_comb begin
        rd_d     = rd_q;
        rd_d.drv = acc_en && (wmask == '0);
        if (rd_d.drv) begin
            rd_d.data = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_drv  = rd_q.drv;
    assign rd_data = rd_q.data;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = bsram_pkg::DEF_ADDR_W,
    parameter int LANES  = bsram_pkg::DEF_LANES,
    parameter int LANE_W = bsram_pkg::DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    strb_host_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_gate_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    oe_n,
    input  logic                    order_sel,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int WORD_W = LANES * LANE_W;

    logic              acc_en;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  wmask;
    logic              rd_drv;
    logic [WORD_W-1:0] rd_data;

    bsram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .ce_a_n      (ce_a_n),
        .ce_b        (ce_b),
        .ce_c_n      (ce_c_n),
        .strb_host_n (strb_host_n),
        .strb_ctl_n  (strb_ctl_n),
        .adv_n       (adv_n),
        .order_sel   (order_sel),
        .sleep       (sleep),
        .acc_en      (acc_en),
        .acc_addr    (acc_addr)
    );

    bsram_wmask #(.LANES(LANES)) wmask_i (
        .wr_all_n  (wr_all_n),
        .wr_gate_n (wr_gate_n),
        .lane_en_n (lane_en_n),
        .wmask     (wmask)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_addr (acc_addr),
        .wmask    (wmask),
        .wdata    (wdata),
        .rd_drv   (rd_drv),
        .rd_data  (rd_data)
    );

    // output enable and sleep gate the pins without a clock
    assign rdata_drv = rd_drv && !oe_n && !sleep;
    assign rdata     = rdata_drv ? rd_data : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int ADDR_W = bsram_pkg::DEF_ADDR_W,
    parameter int LANES  = bsram_pkg::DEF_LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              oe_n,
    input logic              adv_n,
    input logic              strb_host_n,
    input logic              strb_ctl_n,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              wr_all_n,
    input logic              wr_gate_n,
    input logic              order_sel,
    input logic              acc_en,
    input logic [LANES-1:0]  wmask,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rdata_drv
);

    // R10
    sleep_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !acc_en);

    // R7
    deselect_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && !sleep && !(!ce_a_n && ce_b && !ce_c_n)) |-> !acc_en);

    // R6
    global_write_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_n && acc_en) |-> (wmask == '1));

    // R5
    ungated_lanes_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_all_n && wr_gate_n) |-> (wmask == '0));

    // R11
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wmask != '0) |=> !rdata_drv);

    // R2
    read_drives_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wmask == '0) |=> (rdata_drv == (!oe_n && !sleep)));

    // R3
    suspend_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && adv_n && strb_host_n && strb_ctl_n && $stable(order_sel))
            |-> (acc_addr == $past(acc_addr)));

endmodule

bind burst_sram bsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .oe_n        (oe_n),
    .adv_n       (adv_n),
    .strb_host_n (strb_host_n),
    .strb_ctl_n  (strb_ctl_n),
    .ce_a_n      (ce_a_n),
    .ce_b        (ce_b),
    .ce_c_n      (ce_c_n),
    .wr_all_n    (wr_all_n),
    .wr_gate_n   (wr_gate_n),
    .order_sel   (order_sel),
    .acc_en      (acc_en),
    .wmask       (wmask),
    .acc_addr    (acc_addr),
    .rdata_drv   (rdata_drv)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [WW-1:0] wdata;
    logic          ce_a_n, ce_b, ce_c_n;
    logic          strb_host_n, strb_ctl_n, adv_n;
    logic          wr_all_n, wr_gate_n;
    logic [NL-1:0] lane_en_n;
    logic          oe_n, order_sel, sleep;
    logic [WW-1:0] rdata;
    logic          rdata_drv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [WW-1:0] model [1 << AW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n), .lane_en_n(lane_en_n),
        .oe_n(oe_n), .order_sel(order_sel), .sleep(sleep),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        strb_host_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_gate_n = 1'b1; lane_en_n = '1;
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
        oe_n = 1'b0; sleep = 1'b0; wdata = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [WW-1:0] d);
        idle();
        addr = a; wdata = d; strb_ctl_n = 1'b0; wr_all_n = 1'b0;
        cyc();
        chk("R11 no drive after write", {35'd0, rdata_drv}, '0);
        model[a] = d;
        idle();
    endtask

    task automatic start_read(input logic [AW-1:0] a, input bit use_host);
        idle();
        addr = a;
        if (use_host) strb_host_n = 1'b0; else strb_ctl_n = 1'b0;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        idle(); addr = '0; order_sel = 1'b0;
        rst_n = 1'b0;
        repeat (3) cyc();
        chk("R1 drive in reset", {35'd0, rdata_drv}, '0);
        chk("R1 data in reset", rdata, '0);
        rst_n = 1'b1;
        cyc();
        chk("R1 drive after reset", {35'd0, rdata_drv}, '0);
    endtask

    task automatic t_single();
        write_word(8'h05, 36'hA_5A5A_5A5A);
        write_word(8'h06, 36'h1_2345_6789);
        start_read(8'h05, 1'b1);
        chk("R2 read drive", {35'd0, rdata_drv}, 36'd1);
        chk("R2 read word 05", rdata, model[8'h05]);
        start_read(8'h06, 1'b0);
        chk("R6 global write word 06", rdata, model[8'h06]);
    endtask

    task automatic t_linear();
        logic [AW-1:0] seq [5] = '{8'h12, 8'h13, 8'h10, 8'h11, 8'h12};
        for (int i = 0; i < 4; i++) write_word(AW'(8'h10 + i), 36'h7_0000_0100 + WW'(i));
        order_sel = 1'b0;
        start_read(8'h12, 1'b0);
        chk("R3 linear pos0", rdata, model[seq[0]]);
        cyc();
        chk("R3 linear suspend", rdata, model[seq[0]]);
        for (int i = 1; i < 5; i++) begin
            adv_n = 1'b0;
            cyc();
            chk($sformatf("R3 linear pos%0d", i), rdata, model[seq[i]]);
        end
        idle();
    endtask

    task automatic t_interleave();
        logic [AW-1:0] seq [4] = '{8'h11, 8'h10, 8'h13, 8'h12};
        order_sel = 1'b1;
        start_read(8'h11, 1'b1);
        chk("R4 interleaved pos0", rdata, model[seq[0]]);
        for (int i = 1; i < 4; i++) begin
            adv_n = 1'b0;
            cyc();
            chk($sformatf("R4 interleaved pos%0d", i), rdata, model[seq[i]]);
        end
        idle();
        order_sel = 1'b0;
    endtask

    task automatic t_bytes();
        logic [WW-1:0] m;
        logic [WW-1:0] b;
        write_word(8'h20, 36'hF_FFFF_FFFF);
        b = 36'h0_0000_0000;
        m = '0;
        for (int l = 0; l < NL; l++) if (l == 0 || l == 2) m[l*LW +: LW] = '1;
        idle();
        addr = 8'h20; wdata = b; strb_ctl_n = 1'b0;
        wr_gate_n = 1'b0; lane_en_n = 4'b1010;
        cyc();
        model[8'h20] = (model[8'h20] & ~m) | (b & m);
        idle();
        start_read(8'h20, 1'b1);
        chk("R5 lanes 0 and 2 written", rdata, model[8'h20]);
        addr = 8'h20; wdata = 36'h5_5555_5555; strb_ctl_n = 1'b0;
        wr_gate_n = 1'b1; lane_en_n = 4'b0000;
        cyc();
        chk("R5 ungated enables read", rdata, model[8'h20]);
        idle();
        addr = 8'h20; wdata = 36'h3_C3C3_C3C3; strb_ctl_n = 1'b0;
        wr_all_n = 1'b0; wr_gate_n = 1'b1; lane_en_n = 4'b1111;
        cyc();
        model[8'h20] = 36'h3_C3C3_C3C3;
        idle();
        start_read(8'h20, 1'b0);
        chk("R6 global write overrides", rdata, model[8'h20]);
    endtask

    task automatic t_select();
        write_word(8'h30, 36'h2_4680_ACE1);
        idle();
        addr = 8'h30; strb_ctl_n = 1'b0; ce_b = 1'b0;
        cyc();
        chk("R7 ce_b low no drive", {35'd0, rdata_drv}, '0);
        idle();
        addr = 8'h30; strb_ctl_n = 1'b0; ce_c_n = 1'b1;
        wr_all_n = 1'b0; wdata = 36'h0_0000_0BAD;
        cyc();
        chk("R7 ce_c_n high no drive", {35'd0, rdata_drv}, '0);
        idle();
        cyc();
        chk("R7 idle after deselect", {35'd0, rdata_drv}, '0);
        start_read(8'h30, 1'b1);
        chk("R7 deselected write ignored", rdata, model[8'h30]);
    endtask

    task automatic t_strobes();
        start_read(8'h10, 1'b0);
        chk("R8 burst start", rdata, model[8'h10]);
        addr = 8'h20; ce_a_n = 1'b1; strb_host_n = 1'b0;
        cyc();
        chk("R8 host strobe ignored drive", {35'd0, rdata_drv}, 36'd1);
        chk("R8 host strobe ignored data", rdata, model[8'h10]);
        idle();
        addr = 8'h20; ce_a_n = 1'b1; strb_ctl_n = 1'b0;
        cyc();
        chk("R8 controller strobe deselects", {35'd0, rdata_drv}, '0);
        start_read(8'h11, 1'b1);
        chk("R8 restart", rdata, model[8'h11]);
        addr = 8'h12; ce_a_n = 1'b1; strb_host_n = 1'b0; strb_ctl_n = 1'b0;
        cyc();
        chk("R8 both strobes ce_a_n high deselect", {35'd0, rdata_drv}, '0);
        idle();
        addr = 8'h12; strb_host_n = 1'b0; strb_ctl_n = 1'b0;
        cyc();
        chk("R8 both strobes selected", rdata, model[8'h12]);
        idle();
    endtask

    task automatic t_oe();
        start_read(8'h10, 1'b0);
        #1 oe_n = 1'b1;
        #1 chk("R9 oe_n high drive", {35'd0, rdata_drv}, '0);
        chk("R9 oe_n high data", rdata, '0);
        oe_n = 1'b0;
        #1 chk("R9 oe_n low restores", rdata, model[8'h10]);
    endtask

    task automatic t_sleep();
        @(negedge clk);
        start_read(8'h10, 1'b0);
        chk("R10 pre-sleep", rdata, model[8'h10]);
        sleep = 1'b1; adv_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h0_DEAD_BEEF;
        #1 chk("R10 sleep drive off", {35'd0, rdata_drv}, '0);
        @(negedge clk);
        cyc();
        chk("R10 asleep no drive", {35'd0, rdata_drv}, '0);
        idle();
        cyc();
        chk("R10 contents and count kept", rdata, model[8'h10]);
        adv_n = 1'b0;
        cyc();
        chk("R10 count resumes", rdata, model[8'h11]);
        idle();
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        addr = '0; order_sel = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_linear();
        t_interleave();
        t_bytes();
        t_select();
        t_strobes();
        t_oe();
        t_sleep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule